// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block decides when a debug session has seen the event it is waiting for. It takes four comparator match pulses and steps through up to three programmable intermediate states. When it reaches Final it starts bus tracing and, optionally, raises a breakpoint request toward the processor. Each comparator runs in one of two modes, chosen per comparator:

- **Forced.** A match waits for the next instruction boundary.
- **Tagged.** A match marks the opcode that is entering the instruction pipe. It counts only if that opcode survives to execute.

A software trigger input sends an armed sequencer straight to Final. Firmware-side control arms and disarms the sequencer. It also sets the next-state table, the mode of each comparator and the breakpoint kind. The kind is either a background debug entry or a software interrupt. The breakpoint stays raised until the processor acknowledges it, and the sequencer then returns to idle.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset `seq_state` is 0 (Idle), and `trace_start`, `brk_req` and `brk_swi` are low. `seq_state` never holds a value above 4.
- R2: `arm` loads Step1 (`seq_state`=1) from any state at the next rising edge. `disarm` loads Idle (0) at the next rising edge and wins over `arm`. Both also discard pending forced matches and all tags in the pipe.
- R3: In Step1, Step2 or Step3 (codes 1 to 3), `sw_trig` moves the sequencer to Final (4) at the next edge. It wins over every comparator event. In Idle or Final it has no effect.
- R4: In step s (1 to 3), an event on comparator c selects the 3-bit code `nxt_cfg[((s-1)*NCMP+c)*3 +: 3]`. Codes 1, 2 and 3 go to that step, code 4 goes to Final, and codes 0, 5, 6 and 7 cause no move. When several comparators have events, the lowest-numbered one with a moving code wins.
- R5: A match on a comparator with `cmp_tagged[c]`=0, seen while in steps 1 to 3, becomes pending. It produces an event at the first cycle with `insn_bnd` strictly after the match cycle. That boundary clears the pending match whether or not it causes a move.
- R6: A match on a comparator with `cmp_tagged[c]`=1 is captured only in a cycle with `pipe_adv`. It produces an event on the PIPE_D-th later cycle with `pipe_adv` (3 by default). A `pipe_flush` discards every captured tag and wins over `pipe_adv` in the same cycle.
- R7: `trace_start` is high for exactly the first cycle spent in Final.
- R8: On entry to Final, `brk_req` takes `brk_en`, and `brk_swi` takes `brk_swi_sel`, which is 0 for debug entry and 1 for a software interrupt. The request stays high until the edge that samples `brk_ack`, where the sequencer returns to Idle. With `brk_en` low, Final lasts one cycle and then the sequencer returns to Idle.
- R9: In Idle and in Final, comparator matches, boundaries and tag hits do not change `seq_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Load Step1 |
| disarm | input | 1 | Return to Idle |
| sw_trig | input | 1 | Software jump to Final |
| cmp_match | input | NCMP | Comparator match pulses |
| cmp_tagged | input | NCMP | Per comparator: 1 = tagged, 0 = forced |
| nxt_cfg | input | 9*NCMP | Next-state codes, 3 bits per step and comparator |
| insn_bnd | input | 1 | Instruction boundary strobe |
| pipe_adv | input | 1 | Instruction pipe advances by one opcode |
| pipe_flush | input | 1 | Instruction pipe is flushed |
| brk_en | input | 1 | Request a breakpoint on entry to Final |
| brk_swi_sel | input | 1 | Breakpoint kind: 0 debug entry, 1 software interrupt |
| brk_ack | input | 1 | Processor accepts the breakpoint |
| seq_state | output | 3 | 0 Idle, 1 to 3 steps, 4 Final |
| trace_start | output | 1 | One-cycle trace start pulse |
| brk_req | output | 1 | Breakpoint request, held until acknowledged |
| brk_swi | output | 1 | Kind of the pending breakpoint |

## Verification
Every output is registered once, so each result appears after the first rising edge that samples its cause:

- `arm`, `disarm` and `sw_trig` act at the edge right after they are driven.
- A forced match acts no earlier than the edge of a later boundary strobe.
- A tag acts at the edge of the third following pipe advance.

The bench drives inputs at the falling edge. At the next falling edge it compares all outputs with a cycle model built from the requirements, so each check samples half a cycle after the edge that is due to change the result. The directed sequences also place a check on the cycle just before each expected move. This confirms that nothing happens one edge early.

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq #(
  parameter int NCMP   = 4,
  parameter int PIPE_D = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arm,
  input  logic                  disarm,
  input  logic                  sw_trig,
  input  logic [NCMP-1:0]       cmp_match,
  input  logic [NCMP-1:0]       cmp_tagged,
  input  logic [9*NCMP-1:0]     nxt_cfg,
  input  logic                  insn_bnd,
  input  logic                  pipe_adv,
  input  logic                  pipe_flush,
  input  logic                  brk_en,
  input  logic                  brk_swi_sel,
  input  logic                  brk_ack,
  output logic [2:0]            seq_state,
  output logic                  trace_start,
  output logic                  brk_req,
  output logic                  brk_swi
);
  localparam int CW = 3;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_ST1 = 3'd1, S_ST2 = 3'd2, S_ST3 = 3'd3, S_FIN = 3'd4
  } st_t;

  st_t st, st_nx;
  logic armed, entering, clr;
  logic [NCMP-1:0] pend, frc_new, frc_fire, tag_new, tag_hit, ev;
  logic [NCMP-1:0] tpipe [PIPE_D];
  logic [CW-1:0] tgt;

  assign armed    = (st == S_ST1) || (st == S_ST2) || (st == S_ST3);
  assign clr      = arm | disarm;
  assign frc_new  = cmp_match & ~cmp_tagged & {NCMP{armed}};
  assign frc_fire = pend & {NCMP{insn_bnd}};
  assign tag_new  = cmp_match & cmp_tagged & {NCMP{armed & pipe_adv}};
  assign tag_hit  = tpipe[PIPE_D-1] & {NCMP{pipe_adv & ~pipe_flush}};
  assign ev       = frc_fire | tag_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   pend <= '0;
    else if (clr) pend <= '0;
    else          pend <= (pend & ~frc_fire) | frc_new;

  for (genvar g = 0; g < PIPE_D; g++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                  tpipe[g] <= '0;
      else if (clr || pipe_flush)  tpipe[g] <= '0;
      else if (pipe_adv) begin
        if (g == 0) tpipe[g] <= tag_new;
        else        tpipe[g] <= tpipe[(g == 0) ? 0 : g-1];
      end
  end

  always_comb begin
    int base;
    logic [CW-1:0] code;
    base = armed ? (int'(st) - 1) * NCMP : 0;
    tgt  = '0;
    for (int c = NCMP-1; c >= 0; c--) begin
      code = nxt_cfg[(base + c)*CW +: CW];
      if (ev[c] && code != '0 && code <= 3'd4) tgt = code;
    end
  end

  always_comb begin
    st_nx = st;
    if (disarm)   st_nx = S_IDLE;
    else if (arm) st_nx = S_ST1;
    else begin
      case (st)
        S_ST1, S_ST2, S_ST3:
          if (sw_trig)         st_nx = S_FIN;
          else if (tgt != '0)  st_nx = st_t'(tgt);
        S_FIN:
          if (!brk_req || brk_ack) st_nx = S_IDLE;
        default: st_nx = st;
      endcase
    end
  end

  assign entering = (st_nx == S_FIN) && (st != S_FIN);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st          <= S_IDLE;
      trace_start <= 1'b0;
      brk_req     <= 1'b0;
      brk_swi     <= 1'b0;
    end else begin
      st          <= st_nx;
      trace_start <= entering;
      brk_req     <= entering ? brk_en : (brk_req && st_nx == S_FIN);
      brk_swi     <= entering ? (brk_en & brk_swi_sel) : (brk_swi && st_nx == S_FIN);
    end

  assign seq_state = st;
endmodule

module dbg_trig_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       arm,
  input logic       disarm,
  input logic       sw_trig,
  input logic       brk_ack,
  input logic [2:0] seq_state,
  input logic       trace_start,
  input logic       brk_req
);
  p_legal_r1: assert property (@(posedge clk) disable iff (!rst_n) seq_state <= 3'd4);
  p_disarm_r2: assert property (@(posedge clk) disable iff (!rst_n) disarm |=> seq_state == 3'd0);
  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n) arm && !disarm |=> seq_state == 3'd1);
  p_swtrig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state >= 3'd1 && seq_state <= 3'd3) && sw_trig && !arm && !disarm |=> seq_state == 3'd4);
  p_trace_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trace_start |-> seq_state == 3'd4 && $past(seq_state) != 3'd4);
  p_brk_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req && !brk_ack && !arm && !disarm |=> brk_req);
  p_brk_fin_r8: assert property (@(posedge clk) disable iff (!rst_n) brk_req |-> seq_state == 3'd4);
endmodule

bind dbg_trig_seq dbg_trig_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm), .sw_trig(sw_trig),
  .brk_ack(brk_ack), .seq_state(seq_state), .trace_start(trace_start), .brk_req(brk_req)
);

// File: tb/sim_dbg_trig_seq.sv
module sim_dbg_trig_seq;
  localparam int NCMP = 4;
  localparam int PD   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, disarm = 0, sw_trig = 0, insn_bnd = 0, pipe_adv = 0, pipe_flush = 0;
  logic brk_en = 0, brk_swi_sel = 0, brk_ack = 0;
  logic [NCMP-1:0] cmp_match = '0, cmp_tagged = '0;
  logic [9*NCMP-1:0] nxt_cfg = '0;
  logic [2:0] seq_state;
  logic trace_start, brk_req, brk_swi;

  int vecs = 0, errs = 0, cyc = 0;

  int ms = 0;
  logic [NCMP-1:0] mp = '0;
  logic [NCMP-1:0] mt [PD];
  logic mtr = 0, mbr = 0, msw = 0;

  always #4 clk = ~clk;

  dbg_trig_seq #(.NCMP(NCMP), .PIPE_D(PD)) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm), .sw_trig(sw_trig),
    .cmp_match(cmp_match), .cmp_tagged(cmp_tagged), .nxt_cfg(nxt_cfg),
    .insn_bnd(insn_bnd), .pipe_adv(pipe_adv), .pipe_flush(pipe_flush),
    .brk_en(brk_en), .brk_swi_sel(brk_swi_sel), .brk_ack(brk_ack),
    .seq_state(seq_state), .trace_start(trace_start), .brk_req(brk_req), .brk_swi(brk_swi)
  );

  function automatic int code_of(int s, int c);
    return int'(nxt_cfg[((s-1)*NCMP + c)*3 +: 3]);
  endfunction

  task automatic setc(int s, int c, int code);
    nxt_cfg[((s-1)*NCMP + c)*3 +: 3] = 3'(code);
  endtask

  task automatic model_step();
    logic armed_m;
    logic [NCMP-1:0] hit, fire, ev;
    int nms, tg;
    armed_m = (ms >= 1 && ms <= 3);
    hit  = (pipe_adv && !pipe_flush) ? mt[PD-1] : '0;
    fire = insn_bnd ? mp : '0;
    ev   = hit | fire;
    tg = 0;
    if (armed_m)
      for (int c = 0; c < NCMP; c++)
        if (tg == 0 && ev[c] && code_of(ms, c) >= 1 && code_of(ms, c) <= 4) tg = code_of(ms, c);
    nms = ms;
    if (disarm) nms = 0;
    else if (arm) nms = 1;
    else if (armed_m) begin
      if (sw_trig) nms = 4;
      else if (tg != 0) nms = tg;
    end else if (ms == 4) begin
      if (!mbr || brk_ack) nms = 0;
    end
    mtr = (nms == 4 && ms != 4);
    if (mtr) begin mbr = brk_en; msw = brk_en & brk_swi_sel; end
    else begin mbr = mbr && nms == 4; msw = msw && nms == 4; end
    if (arm || disarm) mp = '0;
    else mp = (mp & ~fire) | (armed_m ? (cmp_match & ~cmp_tagged) : '0);
    if (arm || disarm || pipe_flush) for (int i = 0; i < PD; i++) mt[i] = '0;
    else if (pipe_adv) begin
      for (int i = PD-1; i > 0; i--) mt[i] = mt[i-1];
      mt[0] = armed_m ? (cmp_match & cmp_tagged) : '0;
    end
    ms = nms;
  endtask

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    chk("model R4/R5/R6 state", int'(seq_state), ms);
    chk("model R7 trace", int'(trace_start), int'(mtr));
    chk("model R8 brk_req", int'(brk_req), int'(mbr));
    chk("model R8 brk_swi", int'(brk_swi), int'(msw));
  endtask

  task automatic idle_in();
    arm = 0; disarm = 0; sw_trig = 0; cmp_match = '0; insn_bnd = 0;
    pipe_adv = 0; pipe_flush = 0; brk_ack = 0;
  endtask

  initial begin
    for (int i = 0; i < PD; i++) mt[i] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", int'(seq_state), 0);
    chk("R1 reset trace", int'(trace_start), 0);
    chk("R1 reset brk", int'(brk_req), 0);
    chk("R1 reset swi", int'(brk_swi), 0);

    setc(1, 0, 2); setc(2, 1, 3); setc(3, 2, 4); setc(1, 3, 4);
    cmp_tagged = 4'b0100;

    cmp_match = 4'b0001; insn_bnd = 1; tick(); idle_in();
    insn_bnd = 1; tick(); idle_in();
    chk("R9 idle ignores matches", int'(seq_state), 0);

    arm = 1; tick(); idle_in();
    chk("R2 arm loads step1", int'(seq_state), 1);

    cmp_match = 4'b0001; tick(); idle_in();
    chk("R5 no move before boundary", int'(seq_state), 1);
    insn_bnd = 1; tick(); idle_in();
    chk("R5 forced fires at boundary", int'(seq_state), 2);

    cmp_match = 4'b0010; insn_bnd = 1; tick(); idle_in();
    chk("R5 same-cycle boundary does not fire", int'(seq_state), 2);
    insn_bnd = 1; tick(); idle_in();
    chk("R5 fires at later boundary", int'(seq_state), 3);
    insn_bnd = 1; tick(); idle_in();
    chk("R5 pending cleared", int'(seq_state), 3);

    cmp_match = 4'b0100; pipe_adv = 1; tick(); idle_in();
    pipe_adv = 1; tick(); idle_in();
    pipe_flush = 1; pipe_adv = 1; tick(); idle_in();
    repeat (4) begin pipe_adv = 1; tick(); idle_in(); end
    chk("R6 flush drops tag", int'(seq_state), 3);

    brk_en = 1; brk_swi_sel = 1;
    cmp_match = 4'b0100; pipe_adv = 1; tick(); idle_in();
    pipe_adv = 1; tick(); idle_in();
    pipe_adv = 1; tick(); idle_in();
    chk("R6 no hit one advance early", int'(seq_state), 3);
    pipe_adv = 1; tick(); idle_in();
    chk("R6 tag hit reaches final", int'(seq_state), 4);
    chk("R7 trace pulse", int'(trace_start), 1);
    chk("R8 brk raised", int'(brk_req), 1);
    chk("R8 brk kind swi", int'(brk_swi), 1);
    sw_trig = 1; cmp_match = 4'b1111; insn_bnd = 1; tick(); idle_in();
    chk("R9 final holds", int'(seq_state), 4);
    chk("R7 trace one cycle", int'(trace_start), 0);
    chk("R8 brk held", int'(brk_req), 1);
    brk_ack = 1; tick(); idle_in();
    chk("R8 ack returns idle", int'(seq_state), 0);
    chk("R8 brk dropped", int'(brk_req), 0);

    sw_trig = 1; tick(); idle_in();
    chk("R3 sw_trig ignored in idle", int'(seq_state), 0);
    arm = 1; tick(); idle_in();
    brk_en = 0;
    sw_trig = 1; cmp_match = 4'b0001; tick(); idle_in();
    chk("R3 sw_trig to final", int'(seq_state), 4);
    chk("R8 no brk when disabled", int'(brk_req), 0);
    tick();
    chk("R8 final one cycle without brk", int'(seq_state), 0);

    arm = 1; tick(); idle_in();
    cmp_match = 4'b1001; tick(); idle_in();
    insn_bnd = 1; tick(); idle_in();
    chk("R4 lowest comparator wins", int'(seq_state), 2);
    setc(2, 0, 6);
    cmp_match = 4'b0001; tick(); idle_in();
    insn_bnd = 1; tick(); idle_in();
    chk("R4 code 6 no move", int'(seq_state), 2);

    arm = 1; disarm = 1; tick(); idle_in();
    chk("R2 disarm wins", int'(seq_state), 0);

    for (int n = 0; n < 5000; n++) begin
      if (n % 300 == 0) begin
        for (int s = 1; s <= 3; s++)
          for (int c = 0; c < NCMP; c++) setc(s, c, int'($urandom_range(0, 7)));
        cmp_tagged = 4'($urandom());
      end
      arm        = ($urandom_range(0, 99) < 4);
      disarm     = ($urandom_range(0, 99) < 2);
      sw_trig    = ($urandom_range(0, 99) < 2);
      for (int c = 0; c < NCMP; c++) cmp_match[c] = ($urandom_range(0, 99) < 12);
      insn_bnd   = ($urandom_range(0, 99) < 30);
      pipe_adv   = ($urandom_range(0, 99) < 50);
      pipe_flush = ($urandom_range(0, 99) < 5);
      brk_en     = ($urandom_range(0, 1) == 1);
      brk_swi_sel = ($urandom_range(0, 1) == 1);
      brk_ack    = ($urandom_range(0, 99) < 20);
      tick();
    end
    idle_in();

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule